// File: doc/BRIEF.md
# TDMA Stream Link Multiplexer

This block shares one 64-bit point-to-point link among several periodic pixel streams. Each cycle the link carries at most one word. On the transmit side, each stream's 30-bit pixels are packed in pairs into link words and held in a small per-stream buffer. A slot sequencer then walks a programmable schedule table. Each table entry names the stream that owns that cycle. A stream's share of the link is set by how often it appears in the table. Spreading a stream's entries through the table, rather than grouping them, keeps the buffers on both sides small.

Link words carry no header, trailer or checksum. The identity of each word travels on side-band lines beside the data: a valid flag and a stream tag. When a slot's stream has nothing buffered, the valid flag stays low, which marks the slot as idle. On the receive side, each valid word is placed in the output FIFO selected by its tag. Each output FIFO is drained through a valid/ready handshake. A word that arrives for a full FIFO is dropped and latches a per-stream error flag.

The transmit and receive halves sit in one top module. The link outputs and link inputs are separate ports, so the two halves can be connected back to back or to remote partners.

Top module: `tdma_link_mux`

## Requirements
- R1: A link word holds a stream's first pixel in bits 29:0 and its second pixel in bits 59:30, with bits 63:60 zero. A stream's words leave in the order their pixels arrived.
- R2: While `link_en` is high, the schedule position advances one slot per clock. The first slot after enabling is slot 0. Slot i belongs to the stream in table entry i. `cfg_len` holds the schedule length minus one (0..15, giving 1..16 slots), and the position wraps to 0 after the last slot.
- R3: When the current slot's stream has a buffered word, that word goes out with `tx_link_vld`=1 and `tx_link_tag` equal to the stream index. The link outputs are registered and show slot k after the (k+1)-th enabled clock edge.
- R4: When the current slot's stream has no buffered word, the slot is idle: `tx_link_vld`=0, `tx_link_data`=0, and `tx_link_tag` still shows the slot's stream.
- R5: While `link_en` is low, `tx_link_vld` and `tx_link_tag` are 0, and the schedule position returns to slot 0.
- R6: Writes to table entries (`cfg_tbl_we`) and to the length (`cfg_len_we`) take effect only in cycles where `link_en` is low. Writes made while the link is enabled are ignored.
- R7: A received word with `rx_link_vld`=1 is appended to the output FIFO whose index equals `rx_link_tag`. `out_valid`/`out_data` present the oldest word of each FIFO, and a word is removed on a cycle where `out_valid` and `out_ready` are both high.
- R8: A received word for a full output FIFO whose consumer is not reading in that same cycle is dropped, and it sets that stream's bit of `ovf_err`. The bit stays set until reset. If the consumer reads in that same cycle, the word is accepted.
- R9: `in_pix_ready` for a stream is low exactly when that stream holds an unpaired first pixel and its input buffer (4 words) is full.
- R10: After reset, the outputs read as follows: `in_pix_ready` is all ones, the link outputs and `out_valid` are zero, and `ovf_err` is zero. The schedule is a single slot owned by stream 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Runs the transmit schedule when high |
| cfg_tbl_we | input | 1 | Writes one schedule table entry |
| cfg_addr | input | 4 | Table entry index for a write |
| cfg_stream | input | 1 | Stream index written into the entry |
| cfg_len_we | input | 1 | Writes the schedule length |
| cfg_len | input | 4 | Schedule length minus one |
| in_pix_valid | input | 2 | Per-stream pixel valid |
| in_pix_data | input | 60 | Per-stream 30-bit pixels, stream i at bits 30i+29:30i |
| in_pix_ready | output | 2 | Per-stream pixel ready |
| tx_link_vld | output | 1 | Outgoing word present (low means idle slot) |
| tx_link_tag | output | 1 | Outgoing slot stream index |
| tx_link_data | output | 64 | Outgoing link word |
| rx_link_vld | input | 1 | Incoming word present |
| rx_link_tag | input | 1 | Incoming word stream index |
| rx_link_data | input | 64 | Incoming link word |
| out_valid | output | 2 | Per-stream output word available |
| out_ready | input | 2 | Per-stream output consumer ready |
| out_data | output | 128 | Per-stream output words, stream i at bits 64i+63:64i |
| ovf_err | output | 2 | Sticky per-stream receive overflow flags |

## Verification
Two functions can land in the same cycle: an arriving link word for a full output FIFO, and the consumer reading that same FIFO. The bench fills a FIFO to its four-word depth while the consumer is stalled. It then injects a fifth word in a cycle where `out_ready` is high. The expected result is no error flag, and that word sitting at the tail when the FIFO is drained. A sixth word injected against a stalled consumer must be the one that is lost, and it must raise only that stream's flag. The transmit side has the same kind of collision: a slot popping an input buffer in the cycle that buffer frees up after backpressure. The bench judges it by `in_pix_ready` returning high one clock after the link is enabled.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

  // Index width for a count of n items; never narrower than one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Pixel pairing state of one transmit stream.
  typedef enum logic [0:0] {
    PK_EMPTY = 1'b0,
    PK_HALF  = 1'b1
  } pack_state_e;

endpackage

// File: rtl/tdma_fifo.sv
module tdma_fifo #(
  parameter int unsigned W     = 64,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int unsigned AW = tdma_pkg::idx_w(DEPTH);
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= wdata;
  end

endmodule

// File: rtl/tdma_tx_packer.sv
module tdma_tx_packer #(
  parameter int unsigned PIX_W  = 30,
  parameter int unsigned LINK_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_data,
  output logic              pix_ready,
  input  logic              buf_full,
  output logic              word_push,
  output logic [LINK_W-1:0] word_data
);

  import tdma_pkg::*;

  pack_state_e      state_q, state_n;
  logic [PIX_W-1:0] held_q;
  logic             accept;
  logic             hold_en;

  assign pix_ready = (state_q == PK_EMPTY) || !buf_full;
  assign accept    = pix_valid && pix_ready;
  assign hold_en   = accept && (state_q == PK_EMPTY);
  assign word_data = LINK_W'({pix_data, held_q});

  always_comb begin
    state_n   = state_q;
    word_push = 1'b0;
    if (accept) begin
      if (state_q == PK_EMPTY) begin
        state_n = PK_HALF;
      end else begin
        word_push = 1'b1;
        state_n   = PK_EMPTY;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PK_EMPTY;
    else        state_q <= state_n;
  end

  always_ff @(posedge clk) begin
    if (hold_en) held_q <= pix_data;
  end

endmodule

// File: rtl/tdma_slot_seq.sv
module tdma_slot_seq #(
  parameter int unsigned NUM_STREAMS = 2,
  parameter int unsigned SLOTS       = 16,
  parameter int unsigned LINK_W      = 64,
  localparam int unsigned SID_W      = tdma_pkg::idx_w(NUM_STREAMS),
  localparam int unsigned SLOT_AW    = tdma_pkg::idx_w(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_en,
  input  logic                          cfg_tbl_we,
  input  logic [SLOT_AW-1:0]            cfg_addr,
  input  logic [SID_W-1:0]              cfg_stream,
  input  logic                          cfg_len_we,
  input  logic [SLOT_AW-1:0]            cfg_len,
  input  logic [NUM_STREAMS-1:0]        buf_empty,
  input  logic [NUM_STREAMS*LINK_W-1:0] buf_head,
  output logic [NUM_STREAMS-1:0]        buf_pop,
  output logic                          tx_vld,
  output logic [SID_W-1:0]              tx_tag,
  output logic [LINK_W-1:0]             tx_data
);

  logic [SID_W-1:0]   tbl_q [SLOTS];
  logic [SLOT_AW-1:0] len_q;
  logic [SLOT_AW-1:0] ptr_q, ptr_n;
  logic [SID_W-1:0]   cur_sid;
  logic               len_en;
  logic               vld_n;
  logic [SID_W-1:0]   tag_n;
  logic [LINK_W-1:0]  data_n;
  logic               vld_q;
  logic [SID_W-1:0]   tag_q;
  logic [LINK_W-1:0]  data_q;

  // Table entries: each one loads only while the link is stopped.
  for (genvar j = 0; j < SLOTS; j++) begin : g_entry
    logic ent_en;
    assign ent_en = cfg_tbl_we && !link_en && (cfg_addr == SLOT_AW'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tbl_q[j] <= '0;
      else if (ent_en) tbl_q[j] <= cfg_stream;
    end
  end

  assign len_en = cfg_len_we && !link_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= cfg_len;
  end

  assign cur_sid = tbl_q[ptr_q];

  always_comb begin
    if (!link_en)            ptr_n = '0;
    else if (ptr_q == len_q) ptr_n = '0;
    else                     ptr_n = ptr_q + 1'b1;
  end

  always_comb begin
    vld_n  = link_en && !buf_empty[cur_sid];
    tag_n  = link_en ? cur_sid : '0;
    data_n = vld_n ? buf_head[cur_sid*LINK_W +: LINK_W] : '0;
  end

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_pop
    assign buf_pop[i] = vld_n && (cur_sid == SID_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      vld_q  <= 1'b0;
      tag_q  <= '0;
      data_q <= '0;
    end else begin
      ptr_q  <= ptr_n;
      vld_q  <= vld_n;
      tag_q  <= tag_n;
      data_q <= data_n;
    end
  end

  assign tx_vld  = vld_q;
  assign tx_tag  = tag_q;
  assign tx_data = data_q;

endmodule

// File: rtl/tdma_rx_steer.sv
module tdma_rx_steer #(
  parameter int unsigned NUM_STREAMS = 2,
  parameter int unsigned LINK_W      = 64,
  parameter int unsigned OUT_DEPTH   = 4,
  localparam int unsigned SID_W      = tdma_pkg::idx_w(NUM_STREAMS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rx_vld,
  input  logic [SID_W-1:0]              rx_tag,
  input  logic [LINK_W-1:0]             rx_data,
  output logic [NUM_STREAMS-1:0]        out_valid,
  input  logic [NUM_STREAMS-1:0]        out_ready,
  output logic [NUM_STREAMS*LINK_W-1:0] out_data,
  output logic [NUM_STREAMS-1:0]        ovf_err
);

  logic [NUM_STREAMS-1:0] err_q, err_n;
  logic [NUM_STREAMS-1:0] drop;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
    logic hit, pop, full, empty;

    assign hit          = rx_vld && (rx_tag == SID_W'(i));
    assign pop          = out_ready[i] && !empty;
    assign drop[i]      = hit && full && !pop;
    assign out_valid[i] = !empty;

    tdma_fifo #(
      .W     (LINK_W),
      .DEPTH (OUT_DEPTH)
    ) u_out_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (hit),
      .wdata (rx_data),
      .pop   (pop),
      .rdata (out_data[i*LINK_W +: LINK_W]),
      .full  (full),
      .empty (empty)
    );
  end

  assign err_n = err_q | drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_n;
  end

  assign ovf_err = err_q;

endmodule

// File: rtl/tdma_link_mux.sv
module tdma_link_mux #(
  parameter int unsigned NUM_STREAMS = 2,
  parameter int unsigned SLOTS       = 16,
  parameter int unsigned PIX_W       = 30,
  parameter int unsigned LINK_W      = 64,
  parameter int unsigned IN_DEPTH    = 4,
  parameter int unsigned OUT_DEPTH   = 4,
  localparam int unsigned SID_W      = tdma_pkg::idx_w(NUM_STREAMS),
  localparam int unsigned SLOT_AW    = tdma_pkg::idx_w(SLOTS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          link_en,
  input  logic                          cfg_tbl_we,
  input  logic [SLOT_AW-1:0]            cfg_addr,
  input  logic [SID_W-1:0]              cfg_stream,
  input  logic                          cfg_len_we,
  input  logic [SLOT_AW-1:0]            cfg_len,
  input  logic [NUM_STREAMS-1:0]        in_pix_valid,
  input  logic [NUM_STREAMS*PIX_W-1:0]  in_pix_data,
  output logic [NUM_STREAMS-1:0]        in_pix_ready,
  output logic                          tx_link_vld,
  output logic [SID_W-1:0]              tx_link_tag,
  output logic [LINK_W-1:0]             tx_link_data,
  input  logic                          rx_link_vld,
  input  logic [SID_W-1:0]              rx_link_tag,
  input  logic [LINK_W-1:0]             rx_link_data,
  output logic [NUM_STREAMS-1:0]        out_valid,
  input  logic [NUM_STREAMS-1:0]        out_ready,
  output logic [NUM_STREAMS*LINK_W-1:0] out_data,
  output logic [NUM_STREAMS-1:0]        ovf_err
);

  // Reset asserts at once and is released two clocks later.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_core_n = rst_sync_q[1];

  logic [NUM_STREAMS-1:0]        buf_empty;
  logic [NUM_STREAMS-1:0]        buf_pop;
  logic [NUM_STREAMS*LINK_W-1:0] buf_head;

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_tx_lane
    logic              buf_full;
    logic              word_push;
    logic [LINK_W-1:0] word_data;

    tdma_tx_packer #(
      .PIX_W  (PIX_W),
      .LINK_W (LINK_W)
    ) u_packer (
      .clk       (clk),
      .rst_n     (rst_core_n),
      .pix_valid (in_pix_valid[i]),
      .pix_data  (in_pix_data[i*PIX_W +: PIX_W]),
      .pix_ready (in_pix_ready[i]),
      .buf_full  (buf_full),
      .word_push (word_push),
      .word_data (word_data)
    );

    tdma_fifo #(
      .W     (LINK_W),
      .DEPTH (IN_DEPTH)
    ) u_in_fifo (
      .clk   (clk),
      .rst_n (rst_core_n),
      .push  (word_push),
      .wdata (word_data),
      .pop   (buf_pop[i]),
      .rdata (buf_head[i*LINK_W +: LINK_W]),
      .full  (buf_full),
      .empty (buf_empty[i])
    );
  end

  tdma_slot_seq #(
    .NUM_STREAMS (NUM_STREAMS),
    .SLOTS       (SLOTS),
    .LINK_W      (LINK_W)
  ) u_slot_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .link_en    (link_en),
    .cfg_tbl_we (cfg_tbl_we),
    .cfg_addr   (cfg_addr),
    .cfg_stream (cfg_stream),
    .cfg_len_we (cfg_len_we),
    .cfg_len    (cfg_len),
    .buf_empty  (buf_empty),
    .buf_head   (buf_head),
    .buf_pop    (buf_pop),
    .tx_vld     (tx_link_vld),
    .tx_tag     (tx_link_tag),
    .tx_data    (tx_link_data)
  );

  tdma_rx_steer #(
    .NUM_STREAMS (NUM_STREAMS),
    .LINK_W      (LINK_W),
    .OUT_DEPTH   (OUT_DEPTH)
  ) u_rx_steer (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rx_vld    (rx_link_vld),
    .rx_tag    (rx_link_tag),
    .rx_data   (rx_link_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .ovf_err   (ovf_err)
  );

endmodule

// File: rtl/tdma_link_mux_chk.sv
module tdma_link_mux_chk #(
  parameter int unsigned NUM_STREAMS = 2,
  parameter int unsigned LINK_W      = 64,
  parameter int unsigned SID_W       = 1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          link_en,
  input logic                          tx_link_vld,
  input logic [SID_W-1:0]              tx_link_tag,
  input logic [LINK_W-1:0]             tx_link_data,
  input logic                          rx_link_vld,
  input logic [SID_W-1:0]              rx_link_tag,
  input logic [NUM_STREAMS-1:0]        out_valid,
  input logic [NUM_STREAMS-1:0]        out_ready,
  input logic [NUM_STREAMS*LINK_W-1:0] out_data,
  input logic [NUM_STREAMS-1:0]        ovf_err
);

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (!tx_link_vld && tx_link_tag == '0)); // R5

  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_link_vld |-> (tx_link_data == '0)); // R4

  for (genvar i = 0; i < NUM_STREAMS; i++) begin : g_lane
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err[i] |=> ovf_err[i]); // R8

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_err[i]) |-> $past(rx_link_vld && rx_link_tag == SID_W'(i)
                                  && out_valid[i] && !out_ready[i])); // R8

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[i] && !out_ready[i]) |=>
        (out_valid[i] && $stable(out_data[i*LINK_W +: LINK_W]))); // R7
  end

endmodule

bind tdma_link_mux tdma_link_mux_chk #(
  .NUM_STREAMS (NUM_STREAMS),
  .LINK_W      (LINK_W),
  .SID_W       (SID_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .link_en      (link_en),
  .tx_link_vld  (tx_link_vld),
  .tx_link_tag  (tx_link_tag),
  .tx_link_data (tx_link_data),
  .rx_link_vld  (rx_link_vld),
  .rx_link_tag  (rx_link_tag),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .ovf_err      (ovf_err)
);

// File: tb/tdma_link_mux_tb_top.sv
`timescale 1ns/1ps
module tdma_link_mux_tb_top;

  localparam int NS = 2;
  localparam int PW = 30;
  localparam int LW = 64;

  // Walk rows: [3] valid, [2] tag, [1:0] word index within that stream.
  localparam logic [3:0] WALK [9] = '{4'b1000, 4'b1100, 4'b1001, 4'b1010,
                                      4'b1101, 4'b0000, 4'b0000, 4'b0100,
                                      4'b0000};

  logic clk, rst_n, link_en;
  logic cfg_tbl_we, cfg_len_we;
  logic [3:0] cfg_addr, cfg_len;
  logic [0:0] cfg_stream;
  logic [NS-1:0] in_pix_valid, in_pix_ready, out_valid, out_ready, ovf_err;
  logic [NS*PW-1:0] in_pix_data;
  logic tx_vld, rx_vld;
  logic [0:0] tx_tag, rx_tag;
  logic [LW-1:0] tx_data, rx_data;
  logic [NS*LW-1:0] out_data;
  logic inj, inj_vld;
  logic [0:0] inj_tag;
  logic [LW-1:0] inj_data;
  int n_chk, n_fail;

  assign rx_vld  = inj ? inj_vld  : tx_vld;
  assign rx_tag  = inj ? inj_tag  : tx_tag;
  assign rx_data = inj ? inj_data : tx_data;

  tdma_link_mux dut_i (
    .clk(clk), .rst_n(rst_n), .link_en(link_en),
    .cfg_tbl_we(cfg_tbl_we), .cfg_addr(cfg_addr), .cfg_stream(cfg_stream),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len),
    .in_pix_valid(in_pix_valid), .in_pix_data(in_pix_data), .in_pix_ready(in_pix_ready),
    .tx_link_vld(tx_vld), .tx_link_tag(tx_tag), .tx_link_data(tx_data),
    .rx_link_vld(rx_vld), .rx_link_tag(rx_tag), .rx_link_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .ovf_err(ovf_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [PW-1:0] pix(input int s, input int k);
    return PW'(32'h0100_0000 * (s + 1) + k * 3 + 5);
  endfunction

  function automatic logic [LW-1:0] wd(input int s, input int w);
    return LW'({pix(s, 2*w + 1), pix(s, 2*w)});
  endfunction

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_tbl(input int a, input int s);
    cfg_tbl_we = 1'b1; cfg_addr = 4'(a); cfg_stream = 1'(s);
    tick();
    cfg_tbl_we = 1'b0;
  endtask

  task automatic wr_len(input int l);
    cfg_len_we = 1'b1; cfg_len = 4'(l);
    tick();
    cfg_len_we = 1'b0;
  endtask

  task automatic push_pix(input int s, input int k);
    in_pix_valid[s] = 1'b1;
    in_pix_data[s*PW +: PW] = pix(s, k);
    tick();
    in_pix_valid[s] = 1'b0;
  endtask

  task automatic drain_one(input string req, input int s, input logic [LW-1:0] exp);
    chk(req, LW'(out_valid[s]), 64'd1);
    chk(req, out_data[s*LW +: LW], exp);
    out_ready[s] = 1'b1;
    tick();
    out_ready[s] = 1'b0;
  endtask

  task automatic inject(input int s, input logic [LW-1:0] d, input logic rdy);
    inj_vld = 1'b1; inj_tag = 1'(s); inj_data = d; out_ready[s] = rdy;
    tick();
    inj_vld = 1'b0; out_ready[s] = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; link_en = 1'b0; cfg_tbl_we = 1'b0; cfg_len_we = 1'b0;
    cfg_addr = '0; cfg_len = '0; cfg_stream = '0;
    in_pix_valid = '0; in_pix_data = '0; out_ready = '0;
    inj = 1'b0; inj_vld = 1'b0; inj_tag = '0; inj_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) tick();

    // R10 reset state
    chk("R10 ready", LW'(in_pix_ready), 64'h3);
    chk("R10 vld", LW'(tx_vld), 64'h0);
    chk("R10 out_valid", LW'(out_valid), 64'h0);
    chk("R10 err", LW'(ovf_err), 64'h0);

    // R10 default one-slot schedule owned by stream 0
    link_en = 1'b1;
    for (int r = 0; r < 3; r++) begin
      tick();
      chk("R10 default tag", LW'(tx_tag), 64'h0);
    end
    link_en = 1'b0;
    tick();
    chk("R5 stopped vld", LW'(tx_vld), 64'h0);

    // Schedule 0,1,0 and preload 3 words on stream 0, 2 on stream 1
    wr_tbl(0, 0); wr_tbl(1, 1); wr_tbl(2, 0); wr_len(2);
    for (int k = 0; k < 6; k++) push_pix(0, k);
    for (int k = 0; k < 4; k++) push_pix(1, k);

    // R2 R3 R4 table walk; loopback feeds the receiver
    link_en = 1'b1;
    for (int r = 0; r < 9; r++) begin
      tick();
      chk("R2 R3 vld", LW'(tx_vld), LW'(WALK[r][3]));
      chk("R2 tag", LW'(tx_tag), LW'(WALK[r][2]));
      chk("R3 R4 data", tx_data,
          WALK[r][3] ? wd(int'(WALK[r][2]), int'(WALK[r][1:0])) : 64'h0);
    end
    link_en = 1'b0;
    tick();
    chk("R5 stopped vld", LW'(tx_vld), 64'h0);
    chk("R5 stopped tag", LW'(tx_tag), 64'h0);

    // R6 writes while enabled are ignored; R5 restart from slot 0
    link_en = 1'b1;
    cfg_tbl_we = 1'b1; cfg_addr = 4'd1; cfg_stream = 1'b0;
    cfg_len_we = 1'b1; cfg_len = 4'd0;
    tick();
    cfg_tbl_we = 1'b0; cfg_len_we = 1'b0;
    chk("R5 R6 slot0 tag", LW'(tx_tag), 64'h0);
    tick(); chk("R6 slot1 tag", LW'(tx_tag), 64'h1);
    tick(); chk("R6 slot2 tag", LW'(tx_tag), 64'h0);
    tick(); chk("R6 wrap tag", LW'(tx_tag), 64'h0);
    link_en = 1'b0;
    tick();

    // R7 R1 drain received words in order
    for (int w = 0; w < 3; w++) drain_one("R1 R7 s0", 0, wd(0, w));
    for (int w = 0; w < 2; w++) drain_one("R1 R7 s1", 1, wd(1, w));
    chk("R7 empty", LW'(out_valid), 64'h0);

    // R8 overflow and same-cycle read
    inj = 1'b1;
    for (int k = 0; k < 4; k++) inject(1, 64'hA5A5_0000_0000_0000 + LW'(k), 1'b0);
    chk("R8 no err when full", LW'(ovf_err), 64'h0);
    inject(1, 64'hA5A5_0000_0000_0004, 1'b1);
    chk("R8 read same cycle", LW'(ovf_err), 64'h0);
    inject(1, 64'hA5A5_0000_0000_0005, 1'b0);
    chk("R8 err set", LW'(ovf_err), 64'h2);
    for (int k = 1; k < 5; k++) drain_one("R8 R7 kept", 1, 64'hA5A5_0000_0000_0000 + LW'(k));
    chk("R8 dropped", LW'(out_valid), 64'h0);
    chk("R8 sticky", LW'(ovf_err), 64'h2);
    inj = 1'b0;

    // R2 full 16-slot schedule, stream 1 only in the last entry
    wr_tbl(1, 0);
    for (int a = 3; a < 15; a++) wr_tbl(a, 0);
    wr_tbl(15, 1); wr_len(15);
    link_en = 1'b1;
    for (int r = 0; r < 17; r++) begin
      tick();
      chk("R2 len16 tag", LW'(tx_tag), (r == 15) ? 64'h1 : 64'h0);
    end
    link_en = 1'b0;
    tick();

    // R9 input backpressure, then release by a slot pop
    for (int k = 100; k < 109; k++) push_pix(0, k);
    chk("R9 ready low", LW'(in_pix_ready), 64'h2);
    link_en = 1'b1;
    tick();
    link_en = 1'b0;
    chk("R9 ready back", LW'(in_pix_ready), 64'h3);
    chk("R1 R3 word", tx_data, LW'({pix(0, 101), pix(0, 100)}));
    tick();

    summary();
    $finish;
  end

endmodule